// File: doc/BRIEF.md
# I2C Port Expander with Shared DAC Latches

This block is the digital controller of an I2C slave that shares twelve output channels between 8-bit DAC code latches and a bidirectional parallel port. A mode input selects between two personalities. With the mode low, all twelve channels are DAC latches and the bus is write-only. With the mode high, the upper channel pins turn into a parallel port, and the third address pin sets how the channels are split: either four DAC channels plus an 8-bit port, or eight DAC channels plus a 4-bit port.

A write transfer carries a command byte whose low nibble picks a target, followed by data bytes. The target can be a DAC latch, every latch at once, an auto-advancing latch stream, a single port update, or a continuous port stream. A read transfer samples the port and returns its value for as long as the master keeps acknowledging. The block runs on a system clock that is much faster than SCL. It synchronises both bus lines and detects START, STOP and SCL edges internally. It drives SDA as an open-drain pull-down enable. It provides per-bit port output enables, port output data, and the twelve latch codes, which are packed with channel 1 in the lowest byte. Analog conversion and pads are outside this block.

Top module: `pxdac_bridge`

## Requirements
- R1: The slave address is binary 1001 followed by addrPins[2:0], with addrPins[0] as the least significant bit. An address that does not match gets no acknowledge, and the rest of that transfer changes nothing.
- R2: With modeSel low, command low nibble 0001..1100 loads the next data byte into channel 1..12. Nibble 0000 loads the byte into all twelve channels. Nibbles 1101 and 1110 are ignored. Only the first data byte after a single-target command is used. The command upper nibble is don't-care.
- R3: With modeSel low, nibble 1111 writes successive data bytes to channels 1, 2, … 12 and then wraps to channel 1. The stream lasts until the next STOP or START.
- R4: With modeSel low, a read address (R/W bit 1) is not acknowledged, and the port stays high-impedance.
- R5: With modeSel high and addrPins[2]=0, nibbles 0001..0100 load channels 1..4. Nibbles 0101..1110 are ignored.
- R6: With modeSel high and addrPins[2]=1, nibbles 0001..1000 load channels 1..8, and 1001..1110 are ignored. A port write enables only bits 3..0 (portOe = 0x0F) and ignores the upper four bits of the byte, which leaves portOut[7:4] unchanged.
- R7: With modeSel high, nibble 0000 sends the first following data byte to portOut. It enables all port bits when addrPins[2]=0. Later bytes in that transfer are ignored.
- R8: With modeSel high, nibble 1111 sends every following data byte to portOut until the next STOP or START.
- R9: portOut, portOe and the DAC codes change only at the SCL falling edge that ends the acknowledge clock of the data byte. They never change earlier.
- R10: A read samples portIn at the SCL falling edge that starts the first bit of each byte, so a later change of portIn does not alter the byte being shifted. A master ACK leads to a fresh sample for the next byte. A master NACK makes the slave release SDA.
- R11: With modeSel high and addrPins[2]=1, the upper four bits of every read byte are 0.
- R12: portOe is 0 after reset and whenever modeSel is low. It becomes 0 when a read address is acknowledged and stays 0 until the acknowledge of the next port write.
- R13: sdaOe high means SDA is pulled low. The slave acknowledges every matching address it accepts and every byte written after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0: twelve DAC channels; 1: DAC channels plus parallel port |
| addrPins | input | 3 | Low three address bits; bit 2 also sets the channel/port split |
| sclIn | input | 1 | I2C clock line level |
| sdaIn | input | 1 | I2C data line level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| portIn | input | 8 | Parallel port input levels |
| portOut | output | 8 | Parallel port output data |
| portOe | output | 8 | Per-bit parallel port output enable |
| dacCode | output | 96 | Twelve 8-bit DAC codes, channel 1 in bits 7..0 |

## Verification
Writes are tried with each command class in both modes and both split settings. These are single-channel codes just inside and just outside the channel limit, the broadcast code, and the stream code run past the wrap point. Together they separate a correct channel decode from an off-by-one limit or a missing wrap. A second data byte after a one-shot command, and a fresh transfer after a stream, show whether the command lifetime ends where it should. Reads change portIn in the middle of a byte and then between bytes, which tells a sample taken at the byte start from a live or stale one. They end with a NACK, so a released SDA can be distinguished from a slave that keeps driving. Snapshots taken during the acknowledge clock distinguish updates made after the acknowledge from updates made at the end of the eighth bit.

// File: rtl/pxdac_pkg.sv
`timescale 1ns/1ps
package pxdac_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 7;
  localparam int PIN_W  = 3;
  localparam logic [ADDR_W-PIN_W-1:0] ADDR_HI = 4'b1001;
  localparam logic [CMD_W-1:0] CMD_ALL    = 4'h0;
  localparam logic [CMD_W-1:0] CMD_STREAM = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busState_t;

  // strobes from the bus control to the datapath, one clock wide
  typedef struct packed {
    logic              cmdLoad;
    logic              dataLoad;
    logic              portSample;
    logic              readBegin;
    logic              xferEnd;
    logic [BYTE_W-1:0] rxByte;
  } dpStrobe_t;
endpackage

// File: rtl/pxdac_sync.sv
`timescale 1ns/1ps
module pxdac_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[0] <= '1;
        else       chain[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pxdac_ctrl.sv
`timescale 1ns/1ps
module pxdac_ctrl import pxdac_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              modeSel,
  input  logic [PIN_W-1:0]  addrPins,
  input  logic [BYTE_W-1:0] txByte,
  output logic              sdaOe,
  output logic              inRead,
  output dpStrobe_t         stb
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam int IDX_W = $clog2(BYTE_W);

  busState_t         state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic              sclQ, sdaQ;
  logic              isRead, firstByte, masterAck;
  logic              sclRise, sclFall, startEv, stopEv;
  logic              addrHit, addrAccept;
  logic [IDX_W-1:0]  txIdx;

  assign sclRise    = sclS & ~sclQ;
  assign sclFall    = ~sclS & sclQ;
  assign startEv    = sclS & sclQ & sdaQ & ~sdaS;
  assign stopEv     = sclS & sclQ & ~sdaQ & sdaS;
  assign addrHit    = (shReg[BYTE_W-1:1] == {ADDR_HI, addrPins});
  assign addrAccept = addrHit & (~shReg[0] | modeSel);
  assign txIdx      = IDX_W'(BYTE_W - 1) - bitCnt[IDX_W-1:0];
  assign inRead     = (state == ST_RD) || (state == ST_RD_ACK);

  always_comb begin
    stb        = '0;
    stb.rxByte = shReg;
    if (startEv || stopEv) begin
      stb.xferEnd = 1'b1;
    end else begin
      case (state)
        ST_ADDR:     stb.readBegin  = sclFall && (bitCnt == FULL) && addrAccept && shReg[0];
        ST_ADDR_ACK: stb.portSample = sclFall && isRead;
        ST_WR_ACK: begin
          stb.cmdLoad  = sclFall && firstByte;
          stb.dataLoad = sclFall && !firstByte;
        end
        ST_RD_ACK:   stb.portSample = sclFall && masterAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shReg     <= '0;
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      sdaOe     <= 1'b0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
      if (startEv) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopEv) begin
        state  <= ST_IDLE;
        sdaOe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (sclRise && bitCnt != FULL) begin
              shReg  <= {shReg[BYTE_W-2:0], sdaS};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL) begin
              if (state == ST_WR) begin
                state <= ST_WR_ACK;
                sdaOe <= 1'b1;
              end else if (addrAccept) begin
                state  <= ST_ADDR_ACK;
                sdaOe  <= 1'b1;
                isRead <= shReg[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (sclFall) begin
            sdaOe     <= 1'b0;
            bitCnt    <= '0;
            firstByte <= 1'b1;
            state     <= isRead ? ST_RD : ST_WR;
          end
          ST_WR_ACK: if (sclFall) begin
            sdaOe     <= 1'b0;
            bitCnt    <= '0;
            firstByte <= 1'b0;
            state     <= ST_WR;
          end
          ST_RD: begin
            if (sclFall && bitCnt == LAST) begin
              sdaOe <= 1'b0;
              state <= ST_RD_ACK;
            end else begin
              sdaOe <= ~txByte[txIdx];
              if (sclFall) bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (sclRise) masterAck <= ~sdaS;
            if (sclFall) begin
              bitCnt <= '0;
              state  <= masterAck ? ST_RD : ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pxdac_dpath.sv
`timescale 1ns/1ps
module pxdac_dpath import pxdac_pkg::*; #(
  parameter int NUM_CH = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     modeSel,
  input  logic                     narrow,
  input  dpStrobe_t                stb,
  input  logic [BYTE_W-1:0]        portIn,
  output logic [BYTE_W-1:0]        portOut,
  output logic [BYTE_W-1:0]        portOe,
  output logic [BYTE_W-1:0]        txByte,
  output logic [NUM_CH*BYTE_W-1:0] dacCode
);
  localparam int DAC_WIDE   = NUM_CH - BYTE_W;
  localparam int DAC_NARROW = NUM_CH - BYTE_W / 2;
  localparam int PTR_W      = $clog2(NUM_CH);
  localparam logic [BYTE_W-1:0] LOW_MASK = {{(BYTE_W/2){1'b0}}, {(BYTE_W/2){1'b1}}};

  logic [CMD_W-1:0]  cmdCode;
  logic              cmdLive;
  logic [PTR_W-1:0]  seqPtr;
  logic [NUM_CH-1:0] dacHit;
  logic              portHit;
  logic              streaming;
  logic [BYTE_W-1:0] widthMask;
  int                dacLimit;

  assign streaming = (cmdCode == CMD_STREAM);
  assign widthMask = narrow ? LOW_MASK : '1;

  always_comb begin
    dacLimit = !modeSel ? NUM_CH : (narrow ? DAC_NARROW : DAC_WIDE);
    portHit  = 1'b0;
    dacHit   = '0;
    if (stb.dataLoad && cmdLive) begin
      if (modeSel) begin
        portHit = (cmdCode == CMD_ALL) || streaming;
      end else begin
        for (int g = 0; g < NUM_CH; g++) begin
          if (cmdCode == CMD_ALL) dacHit[g] = 1'b1;
          if (streaming && seqPtr == PTR_W'(g)) dacHit[g] = 1'b1;
        end
      end
      for (int g = 0; g < NUM_CH; g++)
        if (g < dacLimit && cmdCode == CMD_W'(g + 1)) dacHit[g] = 1'b1;
    end
  end

  // command lifetime and stream pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCode <= '0;
      cmdLive <= 1'b0;
      seqPtr  <= '0;
    end else if (stb.xferEnd) begin
      cmdLive <= 1'b0;
    end else if (stb.cmdLoad) begin
      cmdCode <= stb.rxByte[CMD_W-1:0];
      cmdLive <= 1'b1;
      seqPtr  <= '0;
    end else if (stb.dataLoad && cmdLive) begin
      if (!streaming) cmdLive <= 1'b0;
      else if (!modeSel)
        seqPtr <= (seqPtr == PTR_W'(NUM_CH - 1)) ? '0 : seqPtr + 1'b1;
    end
  end

  // parallel port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portOut <= '0;
      portOe  <= '0;
      txByte  <= '0;
    end else begin
      if (!modeSel || stb.readBegin) portOe <= '0;
      else if (portHit)              portOe <= widthMask;
      if (portHit) portOut <= (portOut & ~widthMask) | (stb.rxByte & widthMask);
      if (stb.portSample) txByte <= portIn & widthMask;
    end
  end

  // DAC code latches
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lat
    logic [BYTE_W-1:0] code;
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)          code <= '0;
      else if (dacHit[g]) code <= stb.rxByte;
    assign dacCode[g*BYTE_W +: BYTE_W] = code;
  end
endmodule

// File: rtl/pxdac_bridge.sv
`timescale 1ns/1ps
module pxdac_bridge import pxdac_pkg::*; #(
  parameter int NUM_CH      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     modeSel,
  input  logic [PIN_W-1:0]         addrPins,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  output logic                     sdaOe,
  input  logic [BYTE_W-1:0]        portIn,
  output logic [BYTE_W-1:0]        portOut,
  output logic [BYTE_W-1:0]        portOe,
  output logic [NUM_CH*BYTE_W-1:0] dacCode
);
  logic [1:0]        busS;
  logic [BYTE_W-1:0] txByte;
  logic              ctlInRead;
  dpStrobe_t         stb;

  pxdac_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout(busS)
  );

  pxdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(busS[1]), .sdaS(busS[0]),
    .modeSel(modeSel), .addrPins(addrPins), .txByte(txByte),
    .sdaOe(sdaOe), .inRead(ctlInRead), .stb(stb)
  );

  pxdac_dpath #(.NUM_CH(NUM_CH)) u_dpath (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .narrow(addrPins[PIN_W-1]),
    .stb(stb), .portIn(portIn), .portOut(portOut), .portOe(portOe),
    .txByte(txByte), .dacCode(dacCode)
  );
endmodule

// File: rtl/pxdac_bridge_chk.sv
`timescale 1ns/1ps
module pxdac_bridge_chk #(
  parameter int BYTE_W = 8,
  parameter int NUM_CH = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     modeSel,
  input logic                     narrow,
  input logic                     sdaOe,
  input logic                     inRead,
  input logic [BYTE_W-1:0]        portOe,
  input logic [BYTE_W-1:0]        portOut,
  input logic [NUM_CH*BYTE_W-1:0] dacCode
);
  localparam int HALF = BYTE_W / 2;

  AST_MODE_LOW_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel |=> (portOe == '0)) else $error("mode low port enabled"); // R12
  AST_READ_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    inRead |-> (portOe == '0)) else $error("port driven during read"); // R12
  AST_NARROW_OE: assert property (@(posedge clk) disable iff (!rstN)
    narrow |-> (portOe[BYTE_W-1:HALF] == '0)) else $error("upper port enabled"); // R6
  AST_PORT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portOut) |-> $fell(sdaOe)) else $error("port data early"); // R9
  AST_OE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|portOe) |-> $fell(sdaOe)) else $error("port enable early"); // R9
  AST_DAC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> $fell(sdaOe)) else $error("dac code early"); // R9
endmodule

bind pxdac_bridge pxdac_bridge_chk #(.BYTE_W(pxdac_pkg::BYTE_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .narrow(addrPins[2]),
  .sdaOe(sdaOe), .inRead(ctlInRead), .portOe(portOe), .portOut(portOut),
  .dacCode(dacCode)
);

// File: tb/tb_pxdac_bridge.sv
`timescale 1ns/1ps
module tb_pxdac_bridge;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSel = 1'b0;
  logic [2:0]  addrPins = 3'b000;
  logic        scl = 1'b1;
  logic        mLow = 1'b0;
  logic        sdaBus;
  logic        sdaOe;
  logic [7:0]  portIn = 8'h00;
  logic [7:0]  portOut, portOe;
  logic [95:0] dacCode;

  logic [7:0]  snapOut, snapOe;
  logic [95:0] snapDac;
  logic        midSwap = 1'b0;
  logic [7:0]  midVal = 8'h00;
  logic [7:0]  expDac [12];
  int          checks = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;
  assign sdaBus = !(mLow || sdaOe);

  pxdac_bridge dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .addrPins(addrPins),
    .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe), .portIn(portIn),
    .portOut(portOut), .portOe(portOe), .dacCode(dacCode)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] packDac();
    logic [95:0] v;
    for (int i = 0; i < 12; i++) v[i*8 +: 8] = expDac[i];
    return v;
  endfunction

  task automatic doReset(input logic m, input logic [2:0] pins);
    rstN = 1'b0; modeSel = m; addrPins = pins; scl = 1'b1; mLow = 1'b0;
    for (int i = 0; i < 12; i++) expDac[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);
  endtask

  task automatic busStart();
    mLow = 1'b0; scl = 1'b1; tick(Q);
    mLow = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mLow = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    mLow = 1'b0; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    mLow = !b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic getBit(output logic b);
    mLow = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    b = sdaBus; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    mLow = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    acked = !sdaBus;
    snapOut = portOut; snapOe = portOe; snapDac = dacCode;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
      if (midSwap && i == 4) portIn = midVal;
    end
    sendBit(!giveAck);
  endtask

  task automatic wrOne(input logic [6:0] adr, input logic [7:0] cmd, input logic [7:0] dat);
    logic a;
    busStart();
    sendByte({adr, 1'b0}, a); chk("R13 address ack", 96'(a), 96'd1);
    sendByte(cmd, a);         chk("R13 command ack", 96'(a), 96'd1);
    sendByte(dat, a);         chk("R13 data ack", 96'(a), 96'd1);
    busStop();
  endtask

  task automatic testReset();
    doReset(1'b1, 3'b000);
    chk("R12 reset portOe", 96'(portOe), 96'd0);
    chk("R12 reset portOut", 96'(portOut), 96'd0);
    chk("R12 reset dacCode", dacCode, 96'd0);
    chk("R13 reset sdaOe", 96'(sdaOe), 96'd0);
  endtask

  task automatic testLowSingle();
    logic a;
    doReset(1'b0, 3'b010);
    busStart();
    sendByte({7'h4A, 1'b0}, a); chk("R1 matching address acked", 96'(a), 96'd1);
    sendByte(8'h05, a);
    sendByte(8'h3C, a); chk("R9 dac unchanged during ack clock", snapDac, 96'd0);
    busStop();
    expDac[4] = 8'h3C;
    chk("R2 channel 5 load", dacCode, packDac());
    wrOne(7'h4A, 8'hB0, 8'h5A);
    for (int i = 0; i < 12; i++) expDac[i] = 8'h5A;
    chk("R2 broadcast load", dacCode, packDac());
    wrOne(7'h4A, 8'h0D, 8'h99);
    wrOne(7'h4A, 8'h0E, 8'h98);
    chk("R2 codes 1101 and 1110 ignored", dacCode, packDac());
    wrOne(7'h4A, 8'h0C, 8'hC1);
    expDac[11] = 8'hC1;
    chk("R2 channel 12 load", dacCode, packDac());
  endtask

  task automatic testLowStream();
    logic a;
    doReset(1'b0, 3'b111);
    busStart();
    sendByte({7'h4F, 1'b0}, a);
    sendByte(8'hAF, a);
    for (int k = 0; k < 14; k++) begin
      sendByte(8'(8'h10 + k * 7), a);
      expDac[k % 12] = 8'(8'h10 + k * 7);
    end
    busStop();
    chk("R3 stream with wrap to channel 1", dacCode, packDac());
    busStart();
    sendByte({7'h4F, 1'b0}, a);
    sendByte(8'h02, a);
    sendByte(8'h77, a);
    sendByte(8'h88, a);
    busStop();
    expDac[1] = 8'h77;
    chk("R3 stream ended by stop, R2 one byte only", dacCode, packDac());
  endtask

  task automatic testLowRead();
    logic a;
    doReset(1'b0, 3'b010);
    busStart();
    sendByte({7'h4A, 1'b1}, a);
    chk("R4 read address not acked in mode low", 96'(a), 96'd0);
    busStop();
    chk("R4 port stays off", 96'(portOe), 96'd0);
  endtask

  task automatic testMismatch();
    logic a;
    doReset(1'b1, 3'b000);
    busStart();
    sendByte({7'h4B, 1'b0}, a);
    chk("R1 wrong low bits not acked", 96'(a), 96'd0);
    sendByte(8'h00, a);
    sendByte(8'hFF, a);
    busStop();
    busStart();
    sendByte({7'h58, 1'b0}, a);
    chk("R1 wrong high bits not acked", 96'(a), 96'd0);
    sendByte(8'h01, a);
    sendByte(8'h42, a);
    busStop();
    chk("R1 port untouched", {80'd0, portOe, portOut}, 96'd0);
    chk("R1 dac untouched", dacCode, 96'd0);
  endtask

  task automatic testWideMixed();
    logic a;
    doReset(1'b1, 3'b001);
    wrOne(7'h49, 8'h03, 8'h11);
    expDac[2] = 8'h11;
    chk("R5 channel 3 load", dacCode, packDac());
    wrOne(7'h49, 8'h05, 8'h22);
    wrOne(7'h49, 8'h0E, 8'h23);
    chk("R5 codes beyond channel 4 ignored", dacCode, packDac());
    busStart();
    sendByte({7'h49, 1'b0}, a);
    sendByte(8'h00, a);
    sendByte(8'hA5, a);
    chk("R9 port enable unchanged during ack clock", {88'd0, snapOe}, 96'd0);
    chk("R7 port byte applied", {80'd0, portOe, portOut}, {80'd0, 8'hFF, 8'hA5});
    sendByte(8'h3C, a);
    busStop();
    chk("R7 second byte ignored", 96'(portOut), 96'hA5);
    busStart();
    sendByte({7'h49, 1'b0}, a);
    sendByte(8'hEF, a);
    sendByte(8'h01, a); chk("R8 stream byte 1", 96'(portOut), 96'h01);
    sendByte(8'h80, a); chk("R8 stream byte 2", 96'(portOut), 96'h80);
    sendByte(8'hC3, a); chk("R8 stream byte 3", 96'(portOut), 96'hC3);
    busStop();
    wrOne(7'h49, 8'h04, 8'h44);
    expDac[3] = 8'h44;
    chk("R8 stream over, port held", 96'(portOut), 96'hC3);
    chk("R5 channel 4 load", dacCode, packDac());
  endtask

  task automatic testReadWide();
    logic a;
    logic [7:0] v;
    doReset(1'b1, 3'b001);
    wrOne(7'h49, 8'h00, 8'h77);
    portIn = 8'h96; midVal = 8'h5C; midSwap = 1'b1;
    busStart();
    sendByte({7'h49, 1'b1}, a);
    chk("R10 read address acked", 96'(a), 96'd1);
    chk("R12 port released for read", 96'(portOe), 96'd0);
    recvByte(1'b1, v);
    midSwap = 1'b0;
    chk("R10 byte sampled at its start", 96'(v), 96'h96);
    recvByte(1'b0, v);
    chk("R10 resampled after master ack", 96'(v), 96'h5C);
    tick(20);
    chk("R10 SDA released after NACK", {94'd0, sdaOe, sdaBus}, 96'd1);
    busStop();
    chk("R12 port still off after read", 96'(portOe), 96'd0);
    wrOne(7'h49, 8'h00, 8'h3E);
    chk("R12 port back on after write", {80'd0, portOe, portOut}, {80'd0, 8'hFF, 8'h3E});
  endtask

  task automatic testNarrow();
    logic [7:0] v;
    doReset(1'b1, 3'b100);
    wrOne(7'h4C, 8'h08, 8'h81);
    expDac[7] = 8'h81;
    chk("R6 channel 8 load", dacCode, packDac());
    wrOne(7'h4C, 8'h09, 8'h55);
    chk("R6 code 1001 ignored", dacCode, packDac());
    wrOne(7'h4C, 8'h00, 8'hF7);
    chk("R6 low nibble port only", {80'd0, portOe, portOut}, {80'd0, 8'h0F, 8'h07});
    portIn = 8'hEB;
    begin
      logic a;
      busStart();
      sendByte({7'h4C, 1'b1}, a);
      recvByte(1'b0, v);
      busStop();
    end
    chk("R11 upper read bits zero", 96'(v), 96'h0B);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testLowSingle();
    testLowStream();
    testLowRead();
    testMismatch();
    testWideMixed();
    testReadWide();
    testNarrow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule